// File: doc/BRIEF.md
# Two-Level Pin Function Select Bank with Keyed Write Lock

This block holds the pin multiplexing configuration for a group of chip pins. Two register banks sit on a simple valid/ready register bus. The primary bank holds one word per pin that carries a 4-bit function code, a 2-bit pull code and a 2-bit drive-strength code. The secondary bank holds one word per pin whose low six bits form a wider function number. A primary code of 15 defers the pin's selection to that number. The secondary bank also holds two 3-bit source selects, one for each of the two management-data (MDIO) channels. Each select either floats its channel or routes it to one of seven internal peripherals.

The block combines the two words of every pin into one function code. It decodes the pull and drive fields into per-pin outputs. Each bank carries a write lock that the reset sets. Software releases a lock by writing to that bank's protect register the byte address of the protect register itself, with bit 0 set. Writing the plain address locks the bank again. Neither bank's lock affects the other.

The bus uses 32-bit word addresses. Each bank occupies a 2 KB window at a parameterised byte base. Within a window, the per-pin words start at word 0, the protect register is at byte 0x400, and in the secondary bank the MDIO selects for channel 0 and channel 1 are at byte 0x404 and 0x408.

Top module: `pinmux_cfg_bank`

## Requirements
- R1: After reset both banks are locked, every per-pin word and both MDIO selects are zero, and every pin reports function code 0 with high impedance off.
- R2: A write to a bank's protect register of that register's byte address (base + 0x400) locks the bank. The same value with bit 0 set unlocks it. Any other value leaves the lock unchanged. A protect read returns 1 when the bank is locked and 0 when it is open.
- R3: The two banks lock and unlock independently. A protect write to one bank, including one that carries the other bank's key, never changes the other bank's lock.
- R4: A write to a per-pin word or an MDIO select in a locked bank is dropped. Reads work whatever the lock state, and written per-pin words read back in full 32 bits.
- R5: A primary function code (bits 3:0) of 0 to 9 drives pin function code 0 to 9 directly.
- R6: A primary code of 15 drives pin function code 10 + N, where N is bits 5:0 of the secondary word and lies in the range 0 to 61. N = 0 (code 10) also raises the pin's high-impedance output.
- R7: A primary code of 10 to 14, or a primary code of 15 with N of 62 or 63, drives the invalid code 127 and raises high impedance.
- R8: Bits 9:8 of the primary word select the pull: 1 drives pull-up, 3 drives pull-down, and 0 or 2 drive neither.
- R9: Bits 11:10 of the primary word appear on the pin's 2-bit drive output. Codes 0 to 3 stand for 4, 6, 8 and 12 mA.
- R10: Writing an MDIO select stores bits 2:0 of the data. A read returns them zero-extended. The mdioSel output carries channel 1 in bits 5:3 and channel 0 in bits 2:0.
- R11: A write to an unimplemented word address is dropped, and a read from one returns zero. Unimplemented addresses are anything outside the two windows, pin indices at or above the pin count, and the MDIO offsets in the primary bank.
- R12: Every request is accepted in the cycle it is presented. A read returns its data with rspValid high in the next cycle, and a write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted (always high) |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W (30) | Word address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Read data |
| pinFunc | output | 7*NUM_PINS | Resolved function code per pin, pin p at bits 7p+6:7p |
| pinHighZ | output | NUM_PINS | Pin left high impedance |
| pinPullUp | output | NUM_PINS | Pull-up enable per pin |
| pinPullDn | output | NUM_PINS | Pull-down enable per pin |
| pinDrive | output | 2*NUM_PINS | Drive-strength code per pin |
| mdioSel | output | 2*MDIO_W (6) | MDIO source select, channel 1 high |

## Verification
The bench targets the lock key. It tries the right key, the right key with bit 0 set, an unrelated value, and the other bank's key. A design that compared only part of the address, or shared one lock between banks, would open or close the wrong bank. The bench checks the function-code edges 9, 15 with N = 0, 61 and 62, and a primary code of 12. A decoder with an off-by-one limit would return a real function where 127 is required. It also writes to the last pin, the first index past it, and the MDIO offsets in the primary bank. A decoder that did not bound the pin index, or that matched MDIO offsets in both banks, would alias those writes onto real state.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  // Offset field inside one bank window (2 KB = 512 words).
  localparam int OFF_W = 9;
  localparam logic [OFF_W-1:0] PROT_OFF  = 9'h100;
  localparam logic [OFF_W-1:0] MDIO0_OFF = 9'h101;
  localparam logic [OFF_W-1:0] MDIO1_OFF = 9'h102;

  // Resolved function code.
  localparam int FUNC_W = 7;
  localparam logic [FUNC_W-1:0] FUNC_BAD     = 7'd127;
  localparam logic [FUNC_W-1:0] L2_BASE_CODE = 7'd10;
  localparam logic [3:0] L1_DIRECT_MAX = 4'd9;
  localparam logic [3:0] L1_DEFER      = 4'd15;
  localparam logic [5:0] L2_MAX        = 6'd61;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CFG  = 2'd1,
    RD_PROT = 2'd2,
    RD_MDIO = 2'd3
  } rdKind_t;

  typedef enum logic {
    LK_OPEN   = 1'b0,
    LK_LOCKED = 1'b1
  } lock_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             cfgWr;
    logic             mdioWr;
    logic             bank;
    logic             mdioCh;
    logic [OFF_W-1:0] pin;
    logic             rdEn;
    rdKind_t          rdKind;
  } strobe_t;

endpackage

// File: rtl/pinmux_cfg_ctrl.sv
module pinmux_cfg_ctrl
  import pmx_pkg::*;
#(
  parameter int          NUM_PINS = 170,
  parameter int          ADDR_W   = 30,
  parameter logic [31:0] L1_BASE  = 32'h4000_0000,
  parameter logic [31:0] L2_BASE  = 32'h4000_0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output strobe_t           strb,
  output logic [1:0]        lockState
);

  localparam logic [OFF_W-1:0] PIN_LIM = OFF_W'(NUM_PINS);

  logic [1:0]       bankHit;
  logic [OFF_W-1:0] off;
  logic             bankIdx;
  logic             isPin;
  logic             isProt;
  logic             isMdio;

  assign off = reqAddr[OFF_W-1:0];

  // One window decoder and one lock machine per bank.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [31:0] BASE = (b == 0) ? L1_BASE : L2_BASE;
    localparam logic [31:0] KEY  = BASE + 32'h400;
    lock_t lockQ;

    assign bankHit[b] = (reqAddr[ADDR_W-1:OFF_W] == BASE[ADDR_W+1:OFF_W+2]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lockQ <= LK_LOCKED;
      end else if (reqValid && reqWrite && bankHit[b] && (off == PROT_OFF)) begin
        if (reqWdata == KEY)              lockQ <= LK_LOCKED;
        else if (reqWdata == (KEY | 32'd1)) lockQ <= LK_OPEN;
      end
    end

    assign lockState[b] = (lockQ == LK_LOCKED);
  end

  assign bankIdx = bankHit[1];
  assign isPin   = (off < PIN_LIM);
  assign isProt  = (off == PROT_OFF);
  assign isMdio  = bankIdx && ((off == MDIO0_OFF) || (off == MDIO1_OFF));

  always_comb begin
    strb        = '0;
    strb.bank   = bankIdx;
    strb.pin    = off;
    strb.mdioCh = (off == MDIO1_OFF);
    strb.rdEn   = reqValid && !reqWrite;
    if (reqValid && (|bankHit)) begin
      if (reqWrite) begin
        strb.cfgWr  = isPin && !lockState[bankIdx];
        strb.mdioWr = isMdio && !lockState[1];
      end else if (isPin) begin
        strb.rdKind = RD_CFG;
      end else if (isProt) begin
        strb.rdKind = RD_PROT;
      end else if (isMdio) begin
        strb.rdKind = RD_MDIO;
      end
    end
  end

endmodule

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pmx_pkg::*;
#(
  parameter int NUM_PINS = 170,
  parameter int MDIO_W   = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [31:0]                   wdata,
  input  logic [1:0]                    lockState,
  output logic                          rspValid,
  output logic [31:0]                   rspRdata,
  output logic [NUM_PINS-1:0][31:0]     l1Word,
  output logic [NUM_PINS-1:0][31:0]     l2Word,
  output logic [1:0][MDIO_W-1:0]        mdioQ
);

  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [PIN_W-1:0] pinIdx;
  assign pinIdx = strb.pin[PIN_W-1:0];

  if (PIN_W < OFF_W) begin : g_hi
    logic unusedPinHi;
    assign unusedPinHi = ^strb.pin[OFF_W-1:PIN_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l1Word <= '0;
      l2Word <= '0;
      mdioQ  <= '0;
    end else begin
      if (strb.cfgWr && !strb.bank) l1Word[pinIdx] <= wdata;
      if (strb.cfgWr &&  strb.bank) l2Word[pinIdx] <= wdata;
      if (strb.mdioWr) mdioQ[strb.mdioCh] <= wdata[MDIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strb.rdEn;
      case (strb.rdKind)
        RD_CFG:  rspRdata <= strb.bank ? l2Word[pinIdx] : l1Word[pinIdx];
        RD_PROT: rspRdata <= {31'b0, lockState[strb.bank]};
        RD_MDIO: rspRdata <= {{(32-MDIO_W){1'b0}}, mdioQ[strb.mdioCh]};
        default: rspRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pinmux_pin_decode.sv
module pinmux_pin_decode
  import pmx_pkg::*;
(
  input  logic [3:0]        funcCode,
  input  logic [1:0]        pullCode,
  input  logic [1:0]        driveCode,
  input  logic [5:0]        l2Code,
  output logic [FUNC_W-1:0] func,
  output logic              highZ,
  output logic              pullUp,
  output logic              pullDn,
  output logic [1:0]        drive
);

  always_comb begin
    if (funcCode <= L1_DIRECT_MAX) begin
      func = {3'b000, funcCode};
    end else if ((funcCode == L1_DEFER) && (l2Code <= L2_MAX)) begin
      func = FUNC_W'(l2Code) + L2_BASE_CODE;
    end else begin
      func = FUNC_BAD;
    end
  end

  assign highZ  = (func == L2_BASE_CODE) || (func == FUNC_BAD);
  assign pullUp = (pullCode == 2'b01);
  assign pullDn = (pullCode == 2'b11);
  assign drive  = driveCode;

endmodule

// File: rtl/pinmux_cfg_bank.sv
module pinmux_cfg_bank
  import pmx_pkg::*;
#(
  parameter int          NUM_PINS = 170,
  parameter int          ADDR_W   = 30,
  parameter int          MDIO_W   = 3,
  parameter logic [31:0] L1_BASE  = 32'h4000_0000,
  parameter logic [31:0] L2_BASE  = 32'h4000_0800
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [31:0]                  reqWdata,
  output logic                         rspValid,
  output logic [31:0]                  rspRdata,
  output logic [FUNC_W*NUM_PINS-1:0]   pinFunc,
  output logic [NUM_PINS-1:0]          pinHighZ,
  output logic [NUM_PINS-1:0]          pinPullUp,
  output logic [NUM_PINS-1:0]          pinPullDn,
  output logic [2*NUM_PINS-1:0]        pinDrive,
  output logic [2*MDIO_W-1:0]          mdioSel
);

  strobe_t                      strb;
  logic [1:0]                   lockState;
  logic [NUM_PINS-1:0][31:0]    l1Word;
  logic [NUM_PINS-1:0][31:0]    l2Word;
  logic [1:0][MDIO_W-1:0]       mdioQ;

  assign reqReady = 1'b1;

  pinmux_cfg_ctrl #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .L1_BASE(L1_BASE), .L2_BASE(L2_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .strb(strb), .lockState(lockState)
  );

  pinmux_cfg_regs #(
    .NUM_PINS(NUM_PINS), .MDIO_W(MDIO_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(reqWdata), .lockState(lockState),
    .rspValid(rspValid), .rspRdata(rspRdata), .l1Word(l1Word), .l2Word(l2Word),
    .mdioQ(mdioQ)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinmux_pin_decode u_dec (
      .funcCode (l1Word[p][3:0]),
      .pullCode (l1Word[p][9:8]),
      .driveCode(l1Word[p][11:10]),
      .l2Code   (l2Word[p][5:0]),
      .func     (pinFunc[p*FUNC_W +: FUNC_W]),
      .highZ    (pinHighZ[p]),
      .pullUp   (pinPullUp[p]),
      .pullDn   (pinPullDn[p]),
      .drive    (pinDrive[2*p +: 2])
    );
  end

  assign mdioSel = mdioQ;

endmodule

// File: rtl/pinmux_cfg_bank_chk.sv
module pinmux_cfg_bank_chk
  import pmx_pkg::*;
#(
  parameter int          NUM_PINS = 170,
  parameter int          ADDR_W   = 30,
  parameter int          MDIO_W   = 3,
  parameter logic [31:0] L1_BASE  = 32'h4000_0000,
  parameter logic [31:0] L2_BASE  = 32'h4000_0800
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic                       reqWrite,
  input logic [ADDR_W-1:0]          reqAddr,
  input logic [31:0]                reqWdata,
  input logic                       rspValid,
  input logic [FUNC_W*NUM_PINS-1:0] pinFunc,
  input logic [NUM_PINS-1:0]        pinPullUp,
  input logic [NUM_PINS-1:0]        pinPullDn,
  input logic [2*NUM_PINS-1:0]      pinDrive,
  input logic [2*MDIO_W-1:0]        mdioSel,
  input logic [1:0]                 lockState
);

  localparam logic [31:0]       KEY1    = L1_BASE + 32'h400;
  localparam logic [31:0]       KEY2    = L2_BASE + 32'h400;
  localparam logic [ADDR_W-1:0] PROT1_A = ADDR_W'(KEY1 >> 2);
  localparam logic [ADDR_W-1:0] PROT2_A = ADDR_W'(KEY2 >> 2);

  logic rdReq, prot1Wr, prot2Wr;
  assign rdReq   = reqValid && !reqWrite;
  assign prot1Wr = reqValid && reqWrite && (reqAddr == PROT1_A);
  assign prot2Wr = reqValid && reqWrite && (reqAddr == PROT2_A);

  p_rsp_after_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rspValid);
  p_no_rsp_else_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rspValid);

  p_lock_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (prot1Wr && reqWdata == KEY1) |=> lockState[0]);
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (prot1Wr && reqWdata == (KEY1 | 32'd1)) |=> !lockState[0]);
  p_other_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    (prot2Wr && reqWdata != KEY2 && reqWdata != (KEY2 | 32'd1)) |=> $stable(lockState[1]));

  p_bank_indep_r3: assert property (@(posedge clk) disable iff (!rstN)
    prot1Wr |=> $stable(lockState[1]));

  p_locked_mdio_r4: assert property (@(posedge clk) disable iff (!rstN)
    lockState[1] |=> $stable(mdioSel));
  p_locked_pad_r4: assert property (@(posedge clk) disable iff (!rstN)
    lockState[0] |=> ($stable(pinDrive) && $stable(pinPullUp) && $stable(pinPullDn)));

  p_pull_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pinPullUp & pinPullDn) == '0);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    p_func_range_r7: assert property (@(posedge clk) disable iff (!rstN)
      (pinFunc[p*FUNC_W +: FUNC_W] <= 7'd71) || (pinFunc[p*FUNC_W +: FUNC_W] == FUNC_BAD));
  end

endmodule

bind pinmux_cfg_bank pinmux_cfg_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .MDIO_W(MDIO_W),
  .L1_BASE(L1_BASE), .L2_BASE(L2_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
  .pinFunc(pinFunc), .pinPullUp(pinPullUp), .pinPullDn(pinPullDn),
  .pinDrive(pinDrive), .mdioSel(mdioSel), .lockState(lockState)
);

// File: tb/tb_pinmux_cfg_bank.sv
module tb_pinmux_cfg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 170;
  localparam int WATCHDOG = 20000;

  localparam logic [29:0] W1 = 30'h1000_0000;
  localparam logic [29:0] W2 = 30'h1000_0200;
  localparam logic [29:0] P1 = W1 + 30'h100;
  localparam logic [29:0] P2 = W2 + 30'h100;
  localparam logic [29:0] M0 = W2 + 30'h101;
  localparam logic [29:0] M1 = W2 + 30'h102;
  localparam logic [31:0] K1 = 32'h4000_0400;
  localparam logic [31:0] K2 = 32'h4000_0C00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [29:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, rspValid;
  logic [31:0] rspRdata;
  logic [7*NP-1:0] pinFunc;
  logic [NP-1:0] pinHighZ, pinPullUp, pinPullDn;
  logic [2*NP-1:0] pinDrive;
  logic [5:0] mdioSel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_cfg_bank dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .pinFunc(pinFunc),
    .pinHighZ(pinHighZ), .pinPullUp(pinPullUp), .pinPullDn(pinPullDn),
    .pinDrive(pinDrive), .mdioSel(mdioSel)
  );

  typedef struct packed {
    logic        isWr;
    logic [29:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    '{1'b0, P1, 32'h0, 32'h1, 4'd1},            // R1 primary locked
    '{1'b0, P2, 32'h0, 32'h1, 4'd1},            // R1 secondary locked
    '{1'b0, W1+30'd5, 32'h0, 32'h0, 4'd1},      // R1 word zero
    '{1'b1, W1+30'd5, 32'hD03, 32'h0, 4'd4},    // R4 locked write
    '{1'b0, W1+30'd5, 32'h0, 32'h0, 4'd4},
    '{1'b1, P1, K1 | 32'd1, 32'h0, 4'd2},       // R2 unlock
    '{1'b0, P1, 32'h0, 32'h0, 4'd2},
    '{1'b0, P2, 32'h0, 32'h1, 4'd3},            // R3 other still locked
    '{1'b1, W1+30'd5, 32'hD03, 32'h0, 4'd4},
    '{1'b0, W1+30'd5, 32'h0, 32'hD03, 4'd4},
    '{1'b1, P1, 32'h1234_5678, 32'h0, 4'd2},    // R2 junk value
    '{1'b0, P1, 32'h0, 32'h0, 4'd2},
    '{1'b1, P1, K2, 32'h0, 4'd3},               // R3 foreign key
    '{1'b0, P1, 32'h0, 32'h0, 4'd3},
    '{1'b1, W2+30'd5, 32'h21, 32'h0, 4'd4},
    '{1'b0, W2+30'd5, 32'h0, 32'h0, 4'd4},
    '{1'b1, M0, 32'h5, 32'h0, 4'd4},
    '{1'b0, M0, 32'h0, 32'h0, 4'd4},
    '{1'b1, P2, K2 | 32'd1, 32'h0, 4'd2},
    '{1'b0, P2, 32'h0, 32'h0, 4'd2},
    '{1'b0, P1, 32'h0, 32'h0, 4'd3},
    '{1'b1, M0, 32'h5, 32'h0, 4'd10},           // R10
    '{1'b0, M0, 32'h0, 32'h5, 4'd10},
    '{1'b1, M1, 32'hFF, 32'h0, 4'd10},
    '{1'b0, M1, 32'h0, 32'h7, 4'd10},
    '{1'b1, W2+30'd5, 32'h21, 32'h0, 4'd4},
    '{1'b0, W2+30'd5, 32'h0, 32'h21, 4'd4},
    '{1'b1, W1+30'h101, 32'h3, 32'h0, 4'd11},   // R11 no MDIO in primary
    '{1'b0, W1+30'h101, 32'h0, 32'h0, 4'd11},
    '{1'b1, W1+30'd170, 32'h7, 32'h0, 4'd11},   // R11 past last pin
    '{1'b0, W1+30'd170, 32'h0, 32'h0, 4'd11},
    '{1'b0, 30'h0, 32'h0, 32'h0, 4'd11},
    '{1'b1, W1+30'd169, 32'hF, 32'h0, 4'd11},   // last pin is real
    '{1'b0, W1+30'd169, 32'h0, 32'hF, 4'd11},
    '{1'b1, P1, K1, 32'h0, 4'd2},               // R2 relock
    '{1'b0, P1, 32'h0, 32'h1, 4'd2},
    '{1'b1, W1+30'd5, 32'h0, 32'h0, 4'd4},
    '{1'b0, W1+30'd5, 32'h0, 32'hD03, 4'd4},
    '{1'b1, W2+30'h103, 32'h9, 32'h0, 4'd11},
    '{1'b0, W2+30'h103, 32'h0, 32'h0, 4'd11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [29:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk("R12 write no response", {31'b0, rspValid}, 32'h0);
  endtask

  task automatic busRead(input logic [29:0] a, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R12 read response", {31'b0, rspValid}, 32'h1);
    d = rspRdata;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] fn(input int p);
    return {25'b0, pinFunc[p*7 +: 7]};
  endfunction

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    doReset();
    // R1 reset outputs, R12 ready
    chk("R1 func", {31'b0, pinFunc == '0}, 32'h1);
    chk("R1 highZ", {31'b0, pinHighZ == '0}, 32'h1);
    chk("R1 mdioSel", {26'b0, mdioSel}, 32'h0);
    chk("R1 rspValid", {31'b0, rspValid}, 32'h0);
    chk("R12 ready", {31'b0, reqReady}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) begin
        busWrite(VEC[i].addr, VEC[i].data);
      end else begin
        busRead(VEC[i].addr, rd);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // Primary locked, secondary open here. Pin 5 primary = 0xD03.
    chk("R5 pin5 func", fn(5), 32'd3);
    chk("R5 pin5 highZ", {31'b0, pinHighZ[5]}, 32'h0);
    chk("R8 pin5 up", {30'b0, pinPullDn[5], pinPullUp[5]}, 32'h1);
    chk("R9 pin5 drive", {30'b0, pinDrive[11:10]}, 32'h3);
    chk("R6 pin169 func", fn(169), 32'd10);
    chk("R6 pin169 highZ", {31'b0, pinHighZ[169]}, 32'h1);
    chk("R10 mdioSel", {26'b0, mdioSel}, 32'h3D);

    busWrite(P1, K1 | 32'd1);
    busWrite(W1+30'd5, 32'hF);
    chk("R6 pin5 func", fn(5), 32'd43);
    chk("R6 pin5 highZ", {31'b0, pinHighZ[5]}, 32'h0);
    chk("R8 pin5 none", {30'b0, pinPullDn[5], pinPullUp[5]}, 32'h0);
    busWrite(W1+30'd7, 32'hC);
    chk("R7 code 12", fn(7), 32'd127);
    chk("R7 code 12 highZ", {31'b0, pinHighZ[7]}, 32'h1);
    busWrite(W2+30'd7, 32'd62);
    busWrite(W1+30'd7, 32'hF);
    chk("R7 l2 62", fn(7), 32'd127);
    busWrite(W2+30'd7, 32'd61);
    chk("R6 l2 61", fn(7), 32'd71);
    chk("R6 l2 61 highZ", {31'b0, pinHighZ[7]}, 32'h0);
    busWrite(W1+30'd7, 32'h9);
    chk("R5 code 9", fn(7), 32'd9);
    busWrite(W1+30'd8, 32'h300);
    chk("R8 down", {30'b0, pinPullDn[8], pinPullUp[8]}, 32'h2);
    busWrite(W1+30'd8, 32'h200);
    chk("R8 code 2", {30'b0, pinPullDn[8], pinPullUp[8]}, 32'h0);
    busWrite(W1+30'd8, 32'h100);
    chk("R8 up", {30'b0, pinPullDn[8], pinPullUp[8]}, 32'h1);
    busWrite(W1+30'd8, 32'h400);
    chk("R9 drive 1", {30'b0, pinDrive[17:16]}, 32'h1);
    busWrite(W1+30'd8, 32'h800);
    chk("R9 drive 2", {30'b0, pinDrive[17:16]}, 32'h2);

    // R1 reset again
    doReset();
    busRead(P1, rd);
    chk("R1 relock primary", rd, 32'h1);
    busRead(P2, rd);
    chk("R1 relock secondary", rd, 32'h1);
    busRead(W1+30'd5, rd);
    chk("R1 word cleared", rd, 32'h0);
    chk("R1 mdio cleared", {26'b0, mdioSel}, 32'h0);
    chk("R1 func cleared", {31'b0, pinFunc == '0}, 32'h1);

    finishRun();
  end

endmodule